// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block is a per-processor, direct-mapped cache controller that keeps its copies coherent with the other caches on a shared snooping bus. Every line carries one of four coherence states: Invalid, Valid (possibly shared, equal to memory), Reserved (held only here, equal to memory) and Dirty (held only here, memory stale). The first write to a shared line goes through to memory, and the other caches drop their copies. Later writes to that line stay local. A cache that holds a line Dirty supplies the data when another cache reads it.

The processor side presents one read or write at a time and waits for a one-cycle done pulse. The bus side raises a request, waits for a grant, and then performs one single-cycle transaction. On a read the memory data is taken in the granted cycle. A separate snoop port watches the transactions of other masters, updates the line states, and drives intervention data combinationally when it owns a Dirty copy. The bus arbiter and the memory are outside the block. A line holds one word, and the default build has two sets.

Top module: `wonce_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first access to any address misses and issues a bus read (bus_cmd 2'b01). cpu_done, bus_req, bus_cmd and snp_intervene are all low during reset.
- R2: The set index is the low address bit and the tag is the remaining upper bits. Addresses that differ only in the index coexist. Addresses with the same index and different tags replace each other.
- R3: A read miss issues one bus read and installs the line as Valid. The read data is returned with cpu_done. A read hit returns the cached word with no bus transaction.
- R4: A write that hits a Valid line issues one bus write (bus_cmd 2'b10) with the request address and data. Other caches treat that write as an invalidate. The line becomes Reserved.
- R5: A write that hits a Reserved or Dirty line updates only the cache, uses no bus cycle, and leaves the line Dirty.
- R6: A write miss issues a bus read of the line, then a bus write of the new data, and leaves the line Reserved.
- R7: When a snooped read (snp_cmd 2'b01) hits a Dirty line, snp_intervene is high in that same cycle and snp_data carries the line. The line then becomes Valid.
- R8: When a snooped read hits a Reserved line, there is no intervention and the line becomes Valid. A snooped read that hits a Valid line changes nothing.
- R9: When a snooped write (2'b10) or invalidate (2'b11) hits a valid line, that line becomes Invalid. A snooped access that misses has no effect.
- R10: When a miss replaces a Dirty line, the controller first issues a bus write of the old line at its old address, and only then the bus read.
- R11: bus_cmd is non-idle only in a cycle where bus_gnt is high. bus_req stays high while a bus read or a write-through waits for its grant.
- R12: cpu_done is a single-cycle pulse for each request, and cpu_rdata is valid while it is high. Requests are accepted only while the controller is idle.
- R13: If a snoop touches the set of the pending request in the cycle that request is looked up, the snoop is applied first. The lookup is then repeated against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | Processor read request, held until cpu_done |
| cpu_wr | input | 1 | Processor write request, held until cpu_done |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant; the transaction takes place in this cycle |
| bus_cmd | output | 2 | 00 idle, 01 read, 10 write, 11 invalidate |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Data returned for a bus read |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_intervene | output | 1 | This cache supplies the snooped line |
| snp_data | output | DATA_W | Intervention data for requester and memory |

## Verification
A snoop and a processor lookup can land on the same set in the same cycle. The bench provokes this by raising a processor request and driving a snoop in the very next cycle, when the request is being looked up. Directed cases include a snooped read that downgrades a Reserved line just as a local write arrives. The bench judges the result by the bus trace: a write that would have stayed local must instead appear as a write-through, and the intervention flag and data in the snoop cycle must match the pre-write state.

// File: rtl/wonce_pkg.sv
// Shared types for the write-once cache controller.
// Assumes: the bus and snoop command encodings are shared with the rest of the system.
package wonce_pkg;
    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_VAL = 2'd1,
        LN_RSV = 2'd2,
        LN_DRT = 2'd3
    } line_st_e;

    localparam logic [1:0] BC_IDLE  = 2'b00;
    localparam logic [1:0] BC_READ  = 2'b01;
    localparam logic [1:0] BC_WRITE = 2'b10;
    localparam logic [1:0] BC_INVAL = 2'b11;

    typedef enum logic [2:0] {
        FS_IDLE, FS_LOOKUP, FS_FLUSH, FS_FETCH, FS_WTHRU, FS_RESP
    } fsm_e;
endpackage

// File: rtl/wonce_snoop_dec.sv
// Per-set snoop decoder: from one line's state and tag, and the snooped
// command, works out whether the line changes state and whether it must supply data.
// Assumes: sel is high only when a snoop is valid and indexes this set.
module wonce_snoop_dec
    import wonce_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  line_st_e           line_st,
    input  logic [TAG_W-1:0]   line_tag,
    input  logic               sel,
    input  logic [1:0]         cmd,
    input  logic [TAG_W-1:0]   snp_tag,
    output logic               upd,
    output line_st_e           nxt_st,
    output logic               supply
);
    logic hit;
    assign hit = sel && (line_st != LN_INV) && (line_tag == snp_tag);

    // decode the coherence reaction to the snooped command
    always_comb begin
        upd    = 1'b0;
        nxt_st = line_st;
        supply = 1'b0;
        if (hit) begin
            if (cmd == BC_READ) begin
                if (line_st == LN_DRT) begin
                    upd = 1'b1; nxt_st = LN_VAL; supply = 1'b1;
                end else if (line_st == LN_RSV) begin
                    upd = 1'b1; nxt_st = LN_VAL;
                end
            end else if (cmd == BC_WRITE || cmd == BC_INVAL) begin
                upd = 1'b1; nxt_st = LN_INV;
            end
        end
    end
endmodule

// File: rtl/wonce_line_store.sv
// Tag, data and state storage for all sets. It has one lookup port for the
// controller, one write port from the controller, and per-set snoop updates.
// Assumes: the controller never writes a set that a snoop updates in the same
// cycle; if it ever did, the controller write would win.
module wonce_line_store
    import wonce_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    localparam int IDX_W   = $clog2(NUM_SETS),
    localparam int TAG_W   = ADDR_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   lk_idx,
    output line_st_e           lk_state,
    output logic [TAG_W-1:0]   lk_tag,
    output logic [DATA_W-1:0]  lk_data,
    input  logic               we,
    input  logic [IDX_W-1:0]   w_idx,
    input  line_st_e           w_state,
    input  logic [TAG_W-1:0]   w_tag,
    input  logic [DATA_W-1:0]  w_data,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [ADDR_W-1:0]  snp_addr,
    output logic               snp_intervene,
    output logic [DATA_W-1:0]  snp_data
);
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    line_st_e          st_vec  [NUM_SETS];
    logic [TAG_W-1:0]  tag_vec [NUM_SETS];
    logic [DATA_W-1:0] dat_vec [NUM_SETS];
    logic [NUM_SETS-1:0] sup_vec;

    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        localparam logic [IDX_W-1:0] SET_ID = IDX_W'(g);
        line_st_e          st_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] dat_q;
        logic              s_upd;
        line_st_e          s_nxt;
        logic              own_wr;

        assign own_wr = we && (w_idx == SET_ID);

        wonce_snoop_dec #(.TAG_W(TAG_W)) u_dec (
            .line_st (st_q),
            .line_tag(tag_q),
            .sel     (snp_valid && (snp_idx == SET_ID)),
            .cmd     (snp_cmd),
            .snp_tag (snp_tag),
            .upd     (s_upd),
            .nxt_st  (s_nxt),
            .supply  (sup_vec[g])
        );

        // hold one line: controller writes first, snoop updates otherwise
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= LN_INV;
                tag_q <= '0;
                dat_q <= '0;
            end else if (own_wr) begin
                st_q  <= w_state;
                tag_q <= w_tag;
                dat_q <= w_data;
            end else if (s_upd) begin
                st_q  <= s_nxt;
            end
        end

        assign st_vec[g]  = st_q;
        assign tag_vec[g] = tag_q;
        assign dat_vec[g] = dat_q;

        // R7
        snp_dirty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sup_vec[g] && !own_wr) |=> (st_q == LN_VAL));
        // R9
        snp_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (snp_valid && snp_idx == SET_ID && (snp_cmd == BC_WRITE || snp_cmd == BC_INVAL)
             && st_q != LN_INV && tag_q == snp_tag && !own_wr) |=> (st_q == LN_INV));
        // R5
        dirty_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == LN_DRT && $past(st_q) != LN_DRT) |-> ($past(st_q) == LN_RSV));
    end

    assign lk_state      = st_vec[lk_idx];
    assign lk_tag        = tag_vec[lk_idx];
    assign lk_data       = dat_vec[lk_idx];
    assign snp_intervene = |sup_vec;
    assign snp_data      = dat_vec[snp_idx];
endmodule

// File: rtl/wonce_fsm.sv
// Request controller: takes in one processor request, looks it up, and steps
// through the flush, fetch and write-through bus phases it needs.
// Assumes: the bus grant is a single cycle, and bus_rdata is valid in the granted cycle.
module wonce_fsm
    import wonce_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 1,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_done,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [1:0]         bus_cmd,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               snp_valid,
    input  logic [IDX_W-1:0]   snp_idx,
    output logic [IDX_W-1:0]   lk_idx,
    input  line_st_e           lk_state,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [DATA_W-1:0]  lk_data,
    output logic               we,
    output line_st_e           w_state,
    output logic [TAG_W-1:0]   w_tag,
    output logic [DATA_W-1:0]  w_data
);
    fsm_e              st_q, st_d;
    logic              req_wr_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              hit, collide;

    assign req_idx = req_addr_q[IDX_W-1:0];
    assign req_tag = req_addr_q[ADDR_W-1:IDX_W];
    assign lk_idx  = req_idx;
    assign hit     = (lk_state != LN_INV) && (lk_tag == req_tag);
    assign collide = snp_valid && (snp_idx == req_idx);

    // next state, bus drive and line-store write for the current phase
    always_comb begin
        st_d      = st_q;
        rdata_d   = rdata_q;
        we        = 1'b0;
        w_state   = LN_INV;
        w_tag     = req_tag;
        w_data    = req_wdata_q;
        bus_req   = 1'b0;
        bus_cmd   = BC_IDLE;
        bus_addr  = req_addr_q;
        bus_wdata = req_wdata_q;
        case (st_q)
            FS_IDLE:   if (cpu_rd || cpu_wr) st_d = FS_LOOKUP;
            FS_LOOKUP: if (!collide) begin
                if (hit && !req_wr_q) begin
                    rdata_d = lk_data;
                    st_d    = FS_RESP;
                end else if (hit && lk_state == LN_VAL) begin
                    st_d = FS_WTHRU;
                end else if (hit) begin
                    we      = 1'b1;
                    w_state = LN_DRT;
                    st_d    = FS_RESP;
                end else if (lk_state == LN_DRT) begin
                    st_d = FS_FLUSH;
                end else begin
                    st_d = FS_FETCH;
                end
            end
            FS_FLUSH: begin
                if (lk_state != LN_DRT) begin
                    st_d = FS_FETCH;
                end else begin
                    bus_req   = 1'b1;
                    bus_addr  = {lk_tag, req_idx};
                    bus_wdata = lk_data;
                    if (bus_gnt) begin
                        bus_cmd = BC_WRITE;
                        we      = 1'b1;
                        w_state = LN_INV;
                        w_tag   = lk_tag;
                        w_data  = lk_data;
                        st_d    = FS_FETCH;
                    end
                end
            end
            FS_FETCH: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_cmd = BC_READ;
                    we      = 1'b1;
                    w_state = LN_VAL;
                    w_data  = bus_rdata;
                    if (req_wr_q) begin
                        st_d = FS_WTHRU;
                    end else begin
                        rdata_d = bus_rdata;
                        st_d    = FS_RESP;
                    end
                end
            end
            FS_WTHRU: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_cmd = BC_WRITE;
                    we      = 1'b1;
                    w_state = LN_RSV;
                    st_d    = FS_RESP;
                end
            end
            FS_RESP:  st_d = FS_IDLE;
            default:  st_d = FS_IDLE;
        endcase
    end

    // state register, request capture in idle, and read data holding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= FS_IDLE;
            req_wr_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            rdata_q     <= '0;
        end else begin
            st_q    <= st_d;
            rdata_q <= rdata_d;
            if (st_q == FS_IDLE && (cpu_rd || cpu_wr)) begin
                req_wr_q    <= cpu_wr;
                req_addr_q  <= cpu_addr;
                req_wdata_q <= cpu_wdata;
            end
        end
    end

    assign cpu_done  = (st_q == FS_RESP);
    assign cpu_rdata = rdata_q;

    // R11
    cmd_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != BC_IDLE) |-> bus_gnt);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && st_q != FS_FLUSH) |=> bus_req);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);
    // R3
    read_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_LOOKUP && !collide && hit && !req_wr_q) |=> (cpu_done && bus_cmd == BC_IDLE));
    // R13
    collide_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_LOOKUP && collide) |=> (st_q == FS_LOOKUP));
endmodule

// File: rtl/wonce_cache_ctrl.sv
// Top of the write-once snooping cache controller: joins the request
// controller to the line store, which holds the snoop decoders.
// Assumes: an external arbiter never raises bus_gnt in a cycle that carries a
// snoop from another master.
module wonce_cache_ctrl
    import wonce_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               cpu_done,
    output logic               bus_req,
    input  logic               bus_gnt,
    output logic [1:0]         bus_cmd,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               snp_valid,
    input  logic [1:0]         snp_cmd,
    input  logic [ADDR_W-1:0]  snp_addr,
    output logic               snp_intervene,
    output logic [DATA_W-1:0]  snp_data
);
    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  lk_idx;
    line_st_e          lk_state;
    logic [TAG_W-1:0]  lk_tag;
    logic [DATA_W-1:0] lk_data;
    logic              we;
    line_st_e          w_state;
    logic [TAG_W-1:0]  w_tag;
    logic [DATA_W-1:0] w_data;

    wonce_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .cpu_done (cpu_done),
        .bus_req  (bus_req),
        .bus_gnt  (bus_gnt),
        .bus_cmd  (bus_cmd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .snp_valid(snp_valid),
        .snp_idx  (snp_addr[IDX_W-1:0]),
        .lk_idx   (lk_idx),
        .lk_state (lk_state),
        .lk_tag   (lk_tag),
        .lk_data  (lk_data),
        .we       (we),
        .w_state  (w_state),
        .w_tag    (w_tag),
        .w_data   (w_data)
    );

    wonce_line_store #(.NUM_SETS(NUM_SETS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_idx       (lk_idx),
        .lk_state     (lk_state),
        .lk_tag       (lk_tag),
        .lk_data      (lk_data),
        .we           (we),
        .w_idx        (lk_idx),
        .w_state      (w_state),
        .w_tag        (w_tag),
        .w_data       (w_data),
        .snp_valid    (snp_valid),
        .snp_cmd      (snp_cmd),
        .snp_addr     (snp_addr),
        .snp_intervene(snp_intervene),
        .snp_data     (snp_data)
    );

    // R11
    gnt_snoop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> !snp_valid);
    // R7
    intervene_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_intervene |-> (snp_valid && snp_cmd == BC_READ));
endmodule

// File: tb/wonce_cache_ctrl_tb.sv
module wonce_cache_ctrl_tb;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int LIMIT = 150000;

    logic clk, rst_n;
    logic cpu_rd, cpu_wr;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata, cpu_rdata;
    logic cpu_done, bus_req, bus_gnt;
    logic [1:0] bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic snp_valid;
    logic [1:0] snp_cmd;
    logic [AW-1:0] snp_addr;
    logic snp_intervene;
    logic [DW-1:0] snp_data;

    logic [DW-1:0] mem [16];
    assign bus_rdata = mem[bus_addr];

    wonce_cache_ctrl #(.NUM_SETS(2), .ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0, wait_cnt = 0;
    // model of this cache: 0 I, 1 V, 2 R, 3 D
    int m_st [2];
    logic [2:0] m_tag [2];
    logic [DW-1:0] m_dat [2];
    // observed and expected bus traces
    int tr_n, ex_n;
    logic [1:0] tr_c [16], ex_c [16];
    logic [AW-1:0] tr_a [16], ex_a [16];
    logic [DW-1:0] tr_d [16], ex_d [16];
    // pending snoop
    bit sp_pend = 0, sp_exp_sup;
    logic [1:0] sp_cmd;
    logic [AW-1:0] sp_addr;
    logic [DW-1:0] sp_wval, sp_exp_dat;
    string sp_tag;
    bit seen_done;
    logic [DW-1:0] seen_rdata;

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one cycle: drive grant and snoop after the falling edge, then sample
    task automatic step();
        @(negedge clk);
        cyc++;
        bus_gnt = 1'b0;
        if (bus_req) begin
            if (wait_cnt == 0) bus_gnt = 1'b1;
            else wait_cnt--;
        end
        if (sp_pend && !bus_gnt) begin
            snp_valid = 1'b1; snp_cmd = sp_cmd; snp_addr = sp_addr;
        end else begin
            snp_valid = 1'b0; snp_cmd = 2'b00;
        end
        #1;
        if (snp_valid) begin
            check(sp_tag, "snoop intervene", snp_intervene, sp_exp_sup);
            if (sp_exp_sup) check(sp_tag, "intervene data", snp_data, sp_exp_dat);
            if (snp_intervene) mem[sp_addr] = snp_data;
            else if (sp_cmd == 2'b10) mem[sp_addr] = sp_wval;
            sp_pend = 0;
        end
        if (bus_cmd != 2'b00) begin
            if (!bus_gnt) check("R11", "bus cmd without grant", 1, 0);
            if (tr_n < 16) begin
                tr_c[tr_n] = bus_cmd; tr_a[tr_n] = bus_addr; tr_d[tr_n] = bus_wdata;
            end
            tr_n++;
            if (bus_cmd == 2'b10) mem[bus_addr] = bus_wdata;
        end
        if (bus_gnt) wait_cnt = $urandom_range(0, 3);
        if (cpu_done) begin seen_done = 1; seen_rdata = cpu_rdata; end
        if (cyc > LIMIT) begin
            n_chk++; n_bad++;
            $display("FAIL R12 watchdog: actual %0d expected %0d", cyc, LIMIT);
            finish_run();
        end
    endtask

    task automatic push_ex(logic [1:0] c, logic [AW-1:0] a, logic [DW-1:0] d);
        ex_c[ex_n] = c; ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
    endtask

    // apply a snoop to the model and set up its expected outcome
    task automatic plan_snoop(logic [1:0] c, logic [AW-1:0] a, logic [DW-1:0] v);
        int idx = int'(a[0]);
        bit hit = (m_st[idx] != 0) && (m_tag[idx] == a[3:1]);
        sp_cmd = c; sp_addr = a; sp_wval = v; sp_exp_sup = 0; sp_exp_dat = '0;
        sp_tag = (c == 2'b01) ? ((hit && m_st[idx] == 2) ? "R8" : "R7") : "R9";
        if (hit) begin
            if (c == 2'b01) begin
                if (m_st[idx] == 3) begin sp_exp_sup = 1; sp_exp_dat = m_dat[idx]; end
                if (m_st[idx] >= 2) m_st[idx] = 1;
            end else begin
                m_st[idx] = 0;
            end
        end
        sp_pend = 1;
    endtask

    task automatic snoop_only(logic [1:0] c, logic [AW-1:0] a, logic [DW-1:0] v);
        plan_snoop(c, a, v);
        step();
    endtask

    // one processor request, optionally with a snoop during its lookup cycle
    task automatic do_op(bit wr, logic [AW-1:0] a, logic [DW-1:0] wd,
                         bit sn, logic [1:0] sc, logic [AW-1:0] sa, logic [DW-1:0] sv);
        int idx = int'(a[0]);
        bit hit, miss_rd;
        string tag;
        if (sn) plan_snoop(sc, sa, sv);
        hit = (m_st[idx] != 0) && (m_tag[idx] == a[3:1]);
        ex_n = 0; miss_rd = 0;
        if (!hit && m_st[idx] == 3) push_ex(2'b10, {m_tag[idx], a[0]}, m_dat[idx]);
        if (!wr) begin
            tag = hit ? "R3" : ((m_st[idx] == 3) ? "R10" : "R3");
            if (!hit) begin push_ex(2'b01, a, '0); miss_rd = 1; end
        end else if (hit && m_st[idx] == 1) begin
            tag = "R4"; push_ex(2'b10, a, wd);
        end else if (hit) begin
            tag = "R5";
        end else begin
            tag = (m_st[idx] == 3) ? "R10" : "R6";
            push_ex(2'b01, a, '0); push_ex(2'b10, a, wd);
        end
        if (sn && sa[0] == a[0]) tag = "R13";
        tr_n = 0; seen_done = 0;
        cpu_addr = a; cpu_wdata = wd; cpu_wr = wr; cpu_rd = !wr;
        while (!seen_done) step();
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        check(tag, "bus op count", tr_n, ex_n);
        for (int i = 0; i < ex_n && i < tr_n; i++) begin
            check(tag, "bus cmd", tr_c[i], ex_c[i]);
            check(tag, "bus addr", tr_a[i], ex_a[i]);
            if (ex_c[i] == 2'b10) check(tag, "bus wdata", tr_d[i], ex_d[i]);
        end
        if (!wr) check(tag, "read data", seen_rdata, hit ? m_dat[idx] : mem[a]);
        m_tag[idx] = a[3:1];
        if (!wr) begin
            if (miss_rd) begin m_dat[idx] = mem[a]; m_st[idx] = 1; end
        end else begin
            m_dat[idx] = wd;
            m_st[idx] = (hit && m_st[idx] >= 2) ? 3 : 2;
        end
        step();
        check("R12", "done single pulse", cpu_done, 0);
    endtask

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        for (int i = 0; i < 16; i++) mem[i] = DW'($urandom);
        for (int i = 0; i < 2; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
        rst_n = 1'b0; cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
        bus_gnt = 0; snp_valid = 0; snp_cmd = 0; snp_addr = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "done in reset", cpu_done, 0);
        check("R1", "bus_req in reset", bus_req, 0);
        check("R1", "bus_cmd in reset", bus_cmd, 0);
        check("R1", "intervene in reset", snp_intervene, 0);
        rst_n = 1'b1;

        // directed sequence
        do_op(0, 4'd0, '0, 0, 0, 0, 0);
        check("R1", "first access is bus read", tr_c[0], 2'b01);
        do_op(0, 4'd0, '0, 0, 0, 0, 0);
        do_op(0, 4'd1, '0, 0, 0, 0, 0);
        do_op(0, 4'd0, '0, 0, 0, 0, 0);
        check("R2", "other set leaves line", tr_n, 0);
        do_op(0, 4'd2, '0, 0, 0, 0, 0);
        do_op(0, 4'd0, '0, 0, 0, 0, 0);
        check("R2", "same set replaced", tr_n, 1);
        do_op(1, 4'd0, 16'h0001, 0, 0, 0, 0);   // V -> write-through
        do_op(1, 4'd0, 16'h0002, 0, 0, 0, 0);   // R -> D
        do_op(1, 4'd0, 16'h0003, 0, 0, 0, 0);   // D stays
        snoop_only(2'b01, 4'd0, '0);            // intervene
        check("R7", "memory took intervention", mem[0], 16'h0003);
        do_op(1, 4'd0, 16'h0004, 0, 0, 0, 0);   // V -> write-through
        snoop_only(2'b01, 4'd0, '0);            // R -> V quietly
        do_op(1, 4'd0, 16'h0005, 0, 0, 0, 0);
        do_op(1, 4'd0, 16'h0006, 0, 0, 0, 0);   // now D
        do_op(0, 4'd2, '0, 0, 0, 0, 0);         // flush then fetch
        snoop_only(2'b10, 4'd2, 16'h0bad);
        do_op(0, 4'd2, '0, 0, 0, 0, 0);
        snoop_only(2'b11, 4'd2, '0);
        snoop_only(2'b11, 4'd6, '0);            // miss: no effect
        do_op(0, 4'd2, '0, 0, 0, 0, 0);
        do_op(1, 4'd4, 16'h0007, 0, 0, 0, 0);   // write miss
        do_op(1, 4'd4, 16'h0008, 1, 2'b01, 4'd4, '0);  // collision: R downgraded first
        do_op(1, 4'd4, 16'h0009, 0, 0, 0, 0);
        do_op(1, 4'd4, 16'h000a, 1, 2'b01, 4'd4, '0);  // collision with dirty owner
        do_op(1, 4'd5, 16'h000b, 1, 2'b11, 4'd4, '0);  // snoop other set

        // constrained random
        for (int k = 0; k < 400; k++) begin
            logic [AW-1:0] a = AW'($urandom_range(0, 7));
            logic [AW-1:0] sa = AW'($urandom_range(0, 7));
            logic [1:0] sc = 2'($urandom_range(1, 3));
            int r = $urandom_range(0, 99);
            if (r < 20) snoop_only(sc, sa, DW'($urandom));
            else if (r < 35) do_op(bit'($urandom_range(0, 1)), a, DW'($urandom), 1, sc, sa, DW'($urandom));
            else do_op(bit'($urandom_range(0, 1)), a, DW'($urandom), 0, 0, 0, 0);
        end
        finish_run();
    end
endmodule